// File: doc/BRIEF.md
# Asynchronous DRAM Access Cycle Sequencer

The sequencer turns one host request for a single word into the strobe sequence of an asynchronous DRAM with a multiplexed address bus. It starts each access by presenting the row address and pulling the row strobe low. After a programmable delay it presents the column address and pulls the column strobe low. The write strobe, the output enable and the controller's own data-bus drive are then placed according to the cycle type. Every gap between events is a parameter in clock cycles. All event times are measured from the first cycle with the row strobe low, and the package functions compute them.

There are three cycle types. A plain read samples the data bus once both the row and column access times have elapsed. An early write pulls the write strobe low before the column strobe, so the memory never drives its outputs. A read-modify-write first reads the word and returns the output bus to the memory. It then drives a merged word (host data where the mask bit is 1, old data elsewhere) and pulls the write strobe low late, all within one row-strobe period. After the strobes rise, the sequencer holds the row strobe high for the precharge time and pads the access to the minimum cycle length. It pulses `done` and then accepts a new request.

Top module: `dram_seq`

## Requirements
- R1: After reset, `ras_n`, `cas_n`, `we_n` and `oe_n` are high, `dq_oe` and `done` are 0, `ready` is 1.
- R2: When a request is accepted (`req` high while `ready`), the next cycle (cycle 0) has `ras_n` low and `dram_addr` equal to the row. From cycle T_RCD on, `dram_addr` equals the column and `cas_n` is low.
- R3: Early write (`req_op` = 1): `we_n` is low and `dq_oe` is 1 from cycle T_RCD-T_WCS until the strobes rise. `dq_out` equals `req_wdata` and `oe_n` stays high for the whole access.
- R4: Read-modify-write (`req_op` = 2): `we_n` falls at cycle max(SMP+1+T_OFF, T_RCD+T_CWD, T_RWD). The word driven is (old & ~mask) | (wdata & mask), and `rdata` returns the old word.
- R5: `dq_oe` is never 1 while `oe_n` is low. In read-modify-write, `oe_n` is low from cycle T_RCD through the sample cycle SMP, and the drive starts T_OFF cycles after `oe_n` rises.
- R6: Plain read (`req_op` = 0, and code 3, which is treated the same): `we_n` stays high for the whole access and `oe_n` is low from cycle T_RCD until the strobes rise.
- R7: Read data is captured from `dq_in` at the end of cycle SMP = max(T_RAC, T_RCD+T_CAC) and is held on `rdata` while `done` is high.
- R8: `ras_n` and `cas_n` rise together at END: max(SMP+1, T_RCD+T_CAS) for a read, T_RCD+T_CAS for an early write, and the write-strobe cycle plus T_WP for a read-modify-write.
- R9: `done` is high for exactly the one cycle FIN-1, where FIN = max(END+T_RP, T_RC). `ready` is 0 through cycles 0 to FIN-1 and is 1 again at cycle FIN.
- R10: A request presented while `ready` is 0 is ignored: the running access continues unchanged and no new access starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request; taken when `ready` is 1 |
| req_op | input | 2 | 0/3 read, 1 early write, 2 read-modify-write |
| req_row | input | ADDR_W | Row address |
| req_col | input | ADDR_W | Column address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W | Bit select of write data in read-modify-write |
| ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read word |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | DATA_W | Data driven toward memory |
| dq_oe | output | 1 | Tri-state enable for `dq_out` |
| dq_in | input | DATA_W | Data from memory |

## Verification
The assertions assume legal timing parameters: T_WCS no larger than T_RCD, and T_CAS, T_RP and T_WP of at least one. They also assume that the operation code captured with a request stays fixed while the access runs, which the design itself guarantees. The stimulus uses one fixed set of small parameters. It sweeps every code of `req_op` with several row, column, data and mask patterns, including all-zero and all-one masks. It drives `dq_in` with a value that changes every cycle, so a capture taken in the wrong cycle returns a wrong word. Requests injected while busy are lowered before `ready` returns, so they never reach a point where the design is allowed to take them.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_EW  = 2'd1,
    OP_RMW = 2'd2,
    OP_ALT = 2'd3
  } op_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // cycle in which read data is valid at the pins
  function automatic int smp_at(int rac, int rcd, int cac);
    return imax(rac, rcd + cac);
  endfunction

  // cycle in which W falls for read-modify-write
  function automatic int rmw_w_at(int smp, int off, int rcd, int cwd, int rwd);
    return imax(imax(smp + 1 + off, rcd + cwd), rwd);
  endfunction

  // first cycle a new access may start
  function automatic int fin_at(int e_end, int rp, int rc);
    return imax(e_end + rp, rc);
  endfunction

  function automatic op_e norm_op(logic [1:0] code);
    case (code)
      2'd1:    return OP_EW;
      2'd2:    return OP_RMW;
      default: return OP_RD;
    endcase
  endfunction

endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             last,
  output logic             busy,
  output logic [CNT_W-1:0] cyc,
  output logic             nxt_busy,
  output logic [CNT_W-1:0] nxt_cyc
);

  always_comb begin
    nxt_busy = busy;
    nxt_cyc  = cyc;
    if (!busy) begin
      nxt_busy = start;
      nxt_cyc  = '0;
    end else if (last) begin
      nxt_busy = 1'b0;
      nxt_cyc  = '0;
    end else begin
      nxt_cyc = cyc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else begin
      busy <= nxt_busy;
      cyc  <= nxt_cyc;
    end
  end

endmodule

// File: rtl/dram_seq_strobe.sv
module dram_seq_strobe
  import dram_seq_pkg::*;
#(
  parameter int AW        = 4,
  parameter int CNT_W     = 4,
  parameter int P_COL     = 3,
  parameter int P_WEW     = 2,
  parameter int P_SMP     = 6,
  parameter int P_DRV     = 8,
  parameter int P_WRMW    = 8,
  parameter int P_END_RD  = 7,
  parameter int P_END_EW  = 6,
  parameter int P_END_RMW = 10,
  parameter int P_FIN_RD  = 10,
  parameter int P_FIN_EW  = 9,
  parameter int P_FIN_RMW = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nxt_busy,
  input  logic [CNT_W-1:0] nxt_cyc,
  input  op_e              nxt_op,
  input  logic [AW-1:0]    nxt_row,
  input  logic [AW-1:0]    nxt_col,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drv,
  output logic             done,
  output logic [AW-1:0]    addr
);

  int   c, e_end, e_fin;
  logic ras_d, cas_d, we_d, oe_d, drv_d, done_d;

  always_comb begin
    c = int'(nxt_cyc);
    case (nxt_op)
      OP_EW:   begin e_end = P_END_EW;  e_fin = P_FIN_EW;  end
      OP_RMW:  begin e_end = P_END_RMW; e_fin = P_FIN_RMW; end
      default: begin e_end = P_END_RD;  e_fin = P_FIN_RD;  end
    endcase
    ras_d  = nxt_busy && (c < e_end);
    cas_d  = nxt_busy && (c >= P_COL) && (c < e_end);
    done_d = nxt_busy && (c == e_fin - 1);
    we_d   = 1'b0;
    oe_d   = 1'b0;
    drv_d  = 1'b0;
    case (nxt_op)
      OP_EW: begin
        we_d  = nxt_busy && (c >= P_WEW) && (c < e_end);
        drv_d = we_d;
      end
      OP_RMW: begin
        oe_d  = nxt_busy && (c >= P_COL) && (c <= P_SMP);
        drv_d = nxt_busy && (c >= P_DRV) && (c < e_end);
        we_d  = nxt_busy && (c >= P_WRMW) && (c < e_end);
      end
      default: begin
        oe_d = cas_d;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      drv   <= 1'b0;
      done  <= 1'b0;
      addr  <= '0;
    end else begin
      ras_n <= !ras_d;
      cas_n <= !cas_d;
      we_n  <= !we_d;
      oe_n  <= !oe_d;
      drv   <= drv_d;
      done  <= done_d;
      if (nxt_busy) addr <= (int'(nxt_cyc) < P_COL) ? nxt_row : nxt_col;
    end
  end

endmodule

// File: rtl/dram_seq_data.sv
module dram_seq_data
  import dram_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] dq_in,
  input  op_e           op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] dq_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata <= '0;
    else if (cap) rdata <= dq_in;
  end

  always_comb begin
    if (op == OP_RMW) dq_out = (rdata & ~mask) | (wdata & mask);
    else              dq_out = wdata;
  end

endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 3,
  parameter int T_WCS  = 1,
  parameter int T_CAS  = 3,
  parameter int T_RAC  = 6,
  parameter int T_CAC  = 2,
  parameter int T_CWD  = 3,
  parameter int T_RWD  = 6,
  parameter int T_WP   = 2,
  parameter int T_OFF  = 1,
  parameter int T_RP   = 3,
  parameter int T_RC   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [ADDR_W-1:0] req_col,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_mask,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int P_COL     = T_RCD;
  localparam int P_WEW     = T_RCD - T_WCS;
  localparam int P_SMP     = smp_at(T_RAC, T_RCD, T_CAC);
  localparam int P_DRV     = P_SMP + 1 + T_OFF;
  localparam int P_WRMW    = rmw_w_at(P_SMP, T_OFF, T_RCD, T_CWD, T_RWD);
  localparam int P_END_RD  = imax(P_SMP + 1, T_RCD + T_CAS);
  localparam int P_END_EW  = T_RCD + T_CAS;
  localparam int P_END_RMW = P_WRMW + T_WP;
  localparam int P_FIN_RD  = fin_at(P_END_RD, T_RP, T_RC);
  localparam int P_FIN_EW  = fin_at(P_END_EW, T_RP, T_RC);
  localparam int P_FIN_RMW = fin_at(P_END_RMW, T_RP, T_RC);
  localparam int P_FIN_MAX = imax(P_FIN_RMW, imax(P_FIN_RD, P_FIN_EW));
  localparam int CNT_W     = $clog2(P_FIN_MAX + 1);

  logic              busy, nxt_busy, start, last, cap;
  logic [CNT_W-1:0]  cyc, nxt_cyc;
  op_e               op_q, nxt_op;
  logic [ADDR_W-1:0] row_q, col_q;
  logic [DATA_W-1:0] wd_q, mk_q;
  int                fin_cur;

  assign ready  = !busy;
  assign start  = req && !busy;
  assign nxt_op = start ? norm_op(req_op) : op_q;

  always_comb begin
    case (op_q)
      OP_EW:   fin_cur = P_FIN_EW;
      OP_RMW:  fin_cur = P_FIN_RMW;
      default: fin_cur = P_FIN_RD;
    endcase
  end

  assign last = (int'(cyc) == fin_cur - 1);
  assign cap  = busy && (int'(cyc) == P_SMP) && (op_q != OP_EW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_RD;
      row_q <= '0;
      col_q <= '0;
      wd_q  <= '0;
      mk_q  <= '0;
    end else if (start) begin
      op_q  <= nxt_op;
      row_q <= req_row;
      col_q <= req_col;
      wd_q  <= req_wdata;
      mk_q  <= req_mask;
    end
  end

  dram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last),
    .busy(busy), .cyc(cyc), .nxt_busy(nxt_busy), .nxt_cyc(nxt_cyc)
  );

  dram_seq_strobe #(
    .AW(ADDR_W), .CNT_W(CNT_W), .P_COL(P_COL), .P_WEW(P_WEW),
    .P_SMP(P_SMP), .P_DRV(P_DRV), .P_WRMW(P_WRMW),
    .P_END_RD(P_END_RD), .P_END_EW(P_END_EW), .P_END_RMW(P_END_RMW),
    .P_FIN_RD(P_FIN_RD), .P_FIN_EW(P_FIN_EW), .P_FIN_RMW(P_FIN_RMW)
  ) u_strobe (
    .clk(clk), .rst_n(rst_n), .nxt_busy(nxt_busy), .nxt_cyc(nxt_cyc),
    .nxt_op(nxt_op),
    .nxt_row(start ? req_row : row_q),
    .nxt_col(start ? req_col : col_q),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .drv(dq_oe), .done(done), .addr(dram_addr)
  );

  dram_seq_data #(.DW(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .cap(cap), .dq_in(dq_in), .op(op_q),
    .wdata(wd_q), .mask(mk_q), .rdata(rdata), .dq_out(dq_out)
  );

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int AW    = 4,
  parameter int T_WCS = 1,
  parameter int T_CWD = 3,
  parameter int T_RP  = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          done,
  input logic          busy,
  input op_e           op_q,
  input logic [AW-1:0] col_q,
  input logic [AW-1:0] addr
);

  logic [15:0] hi_cnt, wl_cnt, cl_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 16'hFFFF;
      wl_cnt <= '0;
      cl_cnt <= '0;
    end else begin
      hi_cnt <= !ras_n ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
      wl_cnt <= we_n  ? 16'd0 : ((wl_cnt == 16'hFFFF) ? wl_cnt : wl_cnt + 16'd1);
      cl_cnt <= cas_n ? 16'd0 : ((cl_cnt == 16'hFFFF) ? cl_cnt : cl_cnt + 16'd1);
    end
  end

  a_r2_col_at_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> (!ras_n && addr == col_q));

  a_r8_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  a_r3_write_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && op_q == OP_EW) |-> (!we_n && int'(wl_cnt) >= T_WCS));

  a_r3_ew_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_EW) |-> oe_n);

  a_r4_late_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(we_n) && op_q == OP_RMW) |-> (!cas_n && int'(cl_cnt) >= T_CWD));

  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));

  a_r6_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == OP_RD) |-> we_n);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> int'(hi_cnt) >= T_RP);

endmodule

bind dram_seq dram_seq_chk #(
  .AW(ADDR_W), .T_WCS(T_WCS), .T_CWD(T_CWD), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .done(done), .busy(busy), .op_q(op_q),
  .col_q(col_q), .addr(dram_addr)
);

// File: tb/sim_dram_seq.sv
module sim_dram_seq;

  localparam int AW = 4, DW = 8;
  localparam int RCD = 3, WCS = 1, CAS = 3, RAC = 6, CAC = 2;
  localparam int CWD = 3, RWD = 6, WP = 2, OFF = 1, RP = 3, RC = 9;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_row = '0, req_col = '0;
  logic [DW-1:0] req_wdata = '0, req_mask = '0, dq_in = '0;
  logic          ready, done, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rdata, dq_out;
  logic [AW-1:0] dram_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dram_seq #(
    .ADDR_W(AW), .DATA_W(DW), .T_RCD(RCD), .T_WCS(WCS), .T_CAS(CAS),
    .T_RAC(RAC), .T_CAC(CAC), .T_CWD(CWD), .T_RWD(RWD), .T_WP(WP),
    .T_OFF(OFF), .T_RP(RP), .T_RC(RC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .req_mask(req_mask), .ready(ready), .done(done), .rdata(rdata),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one access, checked cycle by cycle from the requirement formulas
  task automatic run(input int code, input int row, input int col,
                     input int wd, input int mk, input int pat, input bit inject);
    int s, e, f, wf, dv, o;
    logic [DW-1:0] old_w, exp_w;
    o  = (code == 1 || code == 2) ? code : 0;
    s  = (RAC > RCD + CAC) ? RAC : RCD + CAC;
    dv = s + 1 + OFF;
    wf = 0;
    if (o == 1) begin
      wf = RCD - WCS;
      e  = RCD + CAS;
    end else if (o == 2) begin
      wf = dv;
      if (RCD + CWD > wf) wf = RCD + CWD;
      if (RWD > wf) wf = RWD;
      e = wf + WP;
    end else begin
      e = (s + 1 > RCD + CAS) ? s + 1 : RCD + CAS;
    end
    f = (e + RP > RC) ? e + RP : RC;
    old_w = DW'(pat) ^ DW'(s);
    exp_w = (o == 2) ? ((old_w & ~DW'(mk)) | (DW'(wd) & DW'(mk))) : DW'(wd);

    req = 1'b1; req_op = 2'(code); req_row = AW'(row); req_col = AW'(col);
    req_wdata = DW'(wd); req_mask = DW'(mk);
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < f; k++) begin
      bit e_ras, e_cas, e_we, e_oe, e_drv;
      dq_in = DW'(pat) ^ DW'(k);
      e_ras = k < e;
      e_cas = (k >= RCD) && (k < e);
      e_we  = (o != 0) && (k >= wf) && (k < e);
      e_oe  = (o == 0 && k >= RCD && k < e) || (o == 2 && k >= RCD && k <= s);
      e_drv = (o == 1 && k >= wf && k < e) || (o == 2 && k >= dv && k < e);
      chk(ras_n == !e_ras, "R8 ras_n", ras_n, !e_ras);
      chk(cas_n == !e_cas, "R2 cas_n", cas_n, !e_cas);
      chk(dram_addr == ((k < RCD) ? AW'(row) : AW'(col)), "R2 addr",
          dram_addr, (k < RCD) ? row : col);
      if (o == 0) chk(we_n == 1'b1, "R6 we_n read", we_n, 1);
      else if (o == 1) chk(we_n == !e_we, "R3 we_n early write", we_n, !e_we);
      else chk(we_n == !e_we, "R4 we_n rmw", we_n, !e_we);
      if (o == 1) chk(oe_n == 1'b1, "R3 oe_n", oe_n, 1);
      else chk(oe_n == !e_oe, "R5 R6 oe_n", oe_n, !e_oe);
      chk(dq_oe == e_drv, "R5 dq_oe", dq_oe, e_drv);
      if (e_drv) begin
        if (o == 2) chk(dq_out == exp_w, "R4 merged word", dq_out, exp_w);
        else chk(dq_out == exp_w, "R3 write word", dq_out, exp_w);
      end
      chk(done == (k == f - 1), "R9 done", done, k == f - 1);
      chk(ready == 1'b0, "R9 ready busy", ready, 0);
      if (k == f - 1 && o != 1) chk(rdata == old_w, "R7 rdata", rdata, old_w);
      if (inject && k == 2) begin
        req = 1'b1; req_op = 2'(3 - code); req_row = ~AW'(row); req_col = ~AW'(col);
      end
      if (inject && k == 4) req = 1'b0;
      @(negedge clk);
    end
    chk(ready == 1'b1, "R9 ready back", ready, 1);
    chk(ras_n == 1'b1, "R10 no extra access", ras_n, 1);
    chk(done == 1'b0, "R9 done low", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(dq_oe == 1'b0 && done == 1'b0, "R1 dq_oe done", {dq_oe, done}, 0);
    chk(ready == 1'b1, "R1 ready", ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 4; i++) begin
        int mk;
        mk = (i == 0) ? 8'h00 : (i == 3) ? 8'hFF : (8'h0F << i) & 8'hFF;
        run(op, (i * 5 + op) & 15, (15 - i * 3) & 15, (8'hA5 ^ (i * 37 + op)) & 8'hFF,
            mk, (8'h3C + i * 17 + op * 11) & 8'hFF, i == 1);
      end
    end
    repeat (3) @(negedge clk);
    chk(ras_n == 1'b1 && ready == 1'b1, "R10 idle after sweep", {ras_n, ready}, 3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule